// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status Registers

This block holds the interrupt-related configuration bytes of a two-channel disk controller and drives a single level-sensitive interrupt line toward the host bus. Each channel reports a pending interrupt in two places at once. One copy is a per-channel legacy status byte. The other is a shared mode byte that also holds a block (suppress) bit for each channel. The two copies are kept equal in both directions. Software clears a pending flag by writing a one to it through either copy.

Two level inputs come from the drives on the two channels. A rising level raises that channel's pending flag in both copies, and a falling level lowers it. A dword-wide configuration write port with per-byte strobes and a combinational dword read port reach the bytes. A separate narrow port sets the two block bits. The interrupt output is high while any channel is pending and not blocked. Every port is a plain strobe or level with no back-pressure: a write presented on a cycle is always applied at that clock edge.

Top module: `irqm_top`

## Requirements
- R1: Channel 0's legacy flag is bit 2 of byte 0x50 and channel 1's legacy flag is bit 4 of byte 0x57. The read port returns, in byte lane i (bits 8*i+7 down to 8*i), the byte at address 4*rd_dw + i.
- R2: In the mode byte 0x71, bit 2 is channel 0 pending, bit 3 is channel 1 pending, bit 4 is channel 0 block and bit 5 is channel 1 block.
- R3: Through the configuration write port, the pending bits of bytes 0x50, 0x57 and 0x71 are cleared by writing one and kept by writing zero. Every other bit of those three bytes ignores configuration writes and stays zero unless set by the rules below.
- R4: After a configuration write clears a legacy flag, the matching pending bit in 0x71 is cleared at the same edge. After a write clears a pending bit in 0x71, the matching legacy flag is cleared at the same edge.
- R5: A rising drive level on a channel sets its pending flag in both copies at the edge that first samples the high level. A falling level clears both copies at the edge that first samples the low level. A steady level changes nothing.
- R6: A block write (blk_we high) loads blk_val[0] into bit 4 and blk_val[1] into bit 5 of 0x71 and changes no other bit. Without a block write, the block bits hold.
- R7: irq_out is registered. After each edge it equals (channel 0 pending and not blocked) or (channel 1 pending and not blocked), evaluated on the state produced by that same edge.
- R8: The control byte 0x51 resets to 0x04, or to 0x0C when SECONDARY_EN is 1. Configuration writes load it in full.
- R9: Byte 0x09 always reads 0x8F and byte 0x3D always reads 0x01. Every other unlisted byte reads zero. Writes to all of these have no effect.
- R10: Updates within one cycle apply in this order: the block write, then the configuration lanes from lowest address to highest, then the drive level edges. A level rise in the same cycle as a clear of the same channel therefore leaves the flag set.
- R11: Synchronous reset clears all pending and block bits and the stored level history, and drives irq_out low. A level already high through reset counts as a rise at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 2 | Interrupt levels from the drives of channel 0 and channel 1 |
| wr_en | input | 1 | Configuration write strobe |
| wr_dw | input | ADDR_W-LB | Dword index of the write (byte address divided by LANES) |
| wr_strb | input | LANES | Byte lane enables of the write |
| wr_data | input | 8*LANES | Write data, byte lane i at bits 8*i+7 down to 8*i |
| blk_we | input | 1 | Block bit write strobe |
| blk_val | input | 2 | New block bits, bit 0 for channel 0 and bit 1 for channel 1 |
| rd_dw | input | ADDR_W-LB | Dword index of the read |
| rd_data | output | 8*LANES | Read data for rd_dw, combinational |
| irq_out | output | 1 | Interrupt level toward the host bus |

## Verification
The bench builds the main instance with SECONDARY_EN at 1, and a second instance with it at 0 whose only purpose is to show the other reset value of the control byte. Both use the default 8-bit byte space and four byte lanes. With four lanes, one write can strike the control byte next to a legacy flag, or hit reserved bits around the mode byte's pending bits. Directed steps set a level edge against a same-cycle clear, hold a level high across reset, and clear flags through each copy. A long random run then mixes level toggles, block writes and strobed writes across every live dword.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  // Byte offsets whose positions other logic decodes
  localparam logic [7:0] OFF_LEG0   = 8'h50;
  localparam logic [7:0] OFF_CTRL   = 8'h51;
  localparam logic [7:0] OFF_LEG1   = 8'h57;
  localparam logic [7:0] OFF_MODE   = 8'h71;
  localparam logic [7:0] OFF_PROGIF = 8'h09;
  localparam logic [7:0] OFF_PIN    = 8'h3D;

  localparam logic [7:0] PROGIF_VAL = 8'h8F;
  localparam logic [7:0] PIN_VAL    = 8'h01;

  // Bit positions
  localparam int LEG0_BIT   = 2;
  localparam int LEG1_BIT   = 4;
  localparam int MODE_PEND0 = 2;
  localparam int MODE_BLK0  = 4;
  localparam int CTRL_EN0   = 2;
  localparam int CTRL_EN1   = 3;

  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [7:0] leg0;
    logic [7:0] ctrl;
    logic [7:0] leg1;
    logic [7:0] mode;
  } irqm_regs_t;

  // Copy the pending bits of the mode byte into the legacy bytes
  function automatic irqm_regs_t legacy_from_mode(input irqm_regs_t r);
    irqm_regs_t o;
    o = r;
    o.leg0[LEG0_BIT] = r.mode[MODE_PEND0];
    o.leg1[LEG1_BIT] = r.mode[MODE_PEND0 + 1];
    return o;
  endfunction

  // Copy the legacy flags into the pending bits of the mode byte
  function automatic irqm_regs_t mode_from_legacy(input irqm_regs_t r);
    irqm_regs_t o;
    o = r;
    o.mode[MODE_PEND0]     = r.leg0[LEG0_BIT];
    o.mode[MODE_PEND0 + 1] = r.leg1[LEG1_BIT];
    return o;
  endfunction

  function automatic logic irq_level(input irqm_regs_t r);
    logic lvl;
    lvl = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      lvl = lvl | (r.mode[MODE_PEND0 + c] & ~r.mode[MODE_BLK0 + c]);
    end
    return lvl;
  endfunction

endpackage

// File: rtl/irqm_level_edge.sv
module irqm_level_edge #(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] lvl,
  output logic [CH-1:0] rise,
  output logic [CH-1:0] fall
);

  logic [CH-1:0] prev_q;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) prev_q[c] <= 1'b0;
      else     prev_q[c] <= lvl[c];
    end
    assign rise[c] = lvl[c] & ~prev_q[c];
    assign fall[c] = ~lvl[c] & prev_q[c];
  end

endmodule

// File: rtl/irqm_cfg_update.sv
module irqm_cfg_update
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LB    = $clog2(LANES),
  localparam int DW_W  = ADDR_W - LB
) (
  input  irqm_regs_t          cur,
  input  logic                blk_we,
  input  logic [1:0]          blk_val,
  input  logic                wr_en,
  input  logic [DW_W-1:0]     wr_dw,
  input  logic [LANES-1:0]    wr_strb,
  input  logic [8*LANES-1:0]  wr_data,
  input  logic [NUM_CH-1:0]   rise,
  input  logic [NUM_CH-1:0]   fall,
  output irqm_regs_t          nxt
);

  irqm_regs_t        r;
  logic [ADDR_W-1:0] la;
  logic [7:0]        bv;

  always_comb begin
    r  = cur;
    la = '0;
    bv = '0;

    // Step 1: block bits from the side port
    if (blk_we) begin
      r.mode[MODE_BLK0]     = blk_val[0];
      r.mode[MODE_BLK0 + 1] = blk_val[1];
      r = legacy_from_mode(r);
    end

    // Step 2: configuration lanes, lowest address first
    for (int i = 0; i < LANES; i++) begin
      if (wr_en && wr_strb[i]) begin
        la = {wr_dw, LB'(i)};
        bv = wr_data[8*i +: 8];
        if (la == ADDR_W'(OFF_LEG0)) begin
          r.leg0[LEG0_BIT] = r.leg0[LEG0_BIT] & ~bv[LEG0_BIT];
          r = mode_from_legacy(r);
        end else if (la == ADDR_W'(OFF_LEG1)) begin
          r.leg1[LEG1_BIT] = r.leg1[LEG1_BIT] & ~bv[LEG1_BIT];
          r = mode_from_legacy(r);
        end else if (la == ADDR_W'(OFF_MODE)) begin
          for (int c = 0; c < NUM_CH; c++) begin
            r.mode[MODE_PEND0 + c] = r.mode[MODE_PEND0 + c] & ~bv[MODE_PEND0 + c];
          end
          r = legacy_from_mode(r);
        end else if (la == ADDR_W'(OFF_CTRL)) begin
          r.ctrl = bv;
        end
      end
    end

    // Step 3: drive level edges
    for (int c = 0; c < NUM_CH; c++) begin
      if (rise[c])      r.mode[MODE_PEND0 + c] = 1'b1;
      else if (fall[c]) r.mode[MODE_PEND0 + c] = 1'b0;
    end
    r = legacy_from_mode(r);

    nxt = r;
  end

endmodule

// File: rtl/irqm_read_mux.sv
module irqm_read_mux
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LB    = $clog2(LANES),
  localparam int DW_W  = ADDR_W - LB
) (
  input  irqm_regs_t         regs,
  input  logic [DW_W-1:0]    rd_dw,
  output logic [8*LANES-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] la;
    assign la = {rd_dw, LB'(g)};
    always_comb begin
      if      (la == ADDR_W'(OFF_LEG0))   rd_data[8*g +: 8] = regs.leg0;
      else if (la == ADDR_W'(OFF_CTRL))   rd_data[8*g +: 8] = regs.ctrl;
      else if (la == ADDR_W'(OFF_LEG1))   rd_data[8*g +: 8] = regs.leg1;
      else if (la == ADDR_W'(OFF_MODE))   rd_data[8*g +: 8] = regs.mode;
      else if (la == ADDR_W'(OFF_PROGIF)) rd_data[8*g +: 8] = PROGIF_VAL;
      else if (la == ADDR_W'(OFF_PIN))    rd_data[8*g +: 8] = PIN_VAL;
      else                                rd_data[8*g +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/irqm_top.sv
module irqm_top
  import irqm_pkg::*;
#(
  parameter int   ADDR_W       = 8,
  parameter int   LANES        = 4,
  parameter logic SECONDARY_EN = 1'b0,
  localparam int  LB           = $clog2(LANES),
  localparam int  DW_W         = ADDR_W - LB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   irq_in,
  input  logic                wr_en,
  input  logic [DW_W-1:0]     wr_dw,
  input  logic [LANES-1:0]    wr_strb,
  input  logic [8*LANES-1:0]  wr_data,
  input  logic                blk_we,
  input  logic [1:0]          blk_val,
  input  logic [DW_W-1:0]     rd_dw,
  output logic [8*LANES-1:0]  rd_data,
  output logic                irq_out
);

  localparam logic [7:0] CTRL_RST =
    (8'(1) << CTRL_EN0) | (SECONDARY_EN ? (8'(1) << CTRL_EN1) : 8'h00);

  irqm_regs_t          regs_q;
  irqm_regs_t          regs_d;
  logic [NUM_CH-1:0]   rise;
  logic [NUM_CH-1:0]   fall;
  logic                irq_q;

  irqm_level_edge #(.CH(NUM_CH)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (irq_in),
    .rise (rise),
    .fall (fall)
  );

  irqm_cfg_update #(.ADDR_W(ADDR_W), .LANES(LANES)) u_upd (
    .cur     (regs_q),
    .blk_we  (blk_we),
    .blk_val (blk_val),
    .wr_en   (wr_en),
    .wr_dw   (wr_dw),
    .wr_strb (wr_strb),
    .wr_data (wr_data),
    .rise    (rise),
    .fall    (fall),
    .nxt     (regs_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q.leg0 <= 8'h00;
      regs_q.ctrl <= CTRL_RST;
      regs_q.leg1 <= 8'h00;
      regs_q.mode <= 8'h00;
      irq_q       <= 1'b0;
    end else begin
      regs_q <= regs_d;
      irq_q  <= irq_level(regs_d);
    end
  end

  irqm_read_mux #(.ADDR_W(ADDR_W), .LANES(LANES)) u_rd (
    .regs    (regs_q),
    .rd_dw   (rd_dw),
    .rd_data (rd_data)
  );

  assign irq_out = irq_q;

endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LB    = $clog2(LANES),
  localparam int DW_W  = ADDR_W - LB
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         irq_in,
  input logic               wr_en,
  input logic [DW_W-1:0]    wr_dw,
  input logic [LANES-1:0]   wr_strb,
  input logic [8*LANES-1:0] wr_data,
  input logic               blk_we,
  input logic [1:0]         blk_val,
  input logic               irq_out,
  input logic [7:0]         leg0,
  input logic [7:0]         leg1,
  input logic [7:0]         mode
);

  localparam logic [DW_W-1:0] MODE_DW   = DW_W'(8'h71 >> LB);
  localparam int              MODE_LANE = 8'h71 % LANES;

  // R4: both copies of each pending flag agree
  p_mirror_ch0_r4: assert property (@(posedge clk) disable iff (rst)
    leg0[2] == mode[2]);
  p_mirror_ch1_r4: assert property (@(posedge clk) disable iff (rst)
    leg1[4] == mode[3]);

  // R3: bits outside pending and block stay zero
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (mode[7:6] == 2'b00) && (mode[1:0] == 2'b00) &&
    ((leg0 & 8'hFB) == 8'h00) && ((leg1 & 8'hEF) == 8'h00));

  // R3: writing one to channel 0 pending in the mode byte clears it,
  // unless a level rise arrives in the same cycle (R10)
  p_w1c_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_strb[MODE_LANE] && (wr_dw == MODE_DW) &&
     wr_data[8*MODE_LANE + 2] && !(irq_in[0] && !$past(irq_in[0])))
    |=> !mode[2]);

  // R5: rising level sets, falling level clears
  p_rise_ch0_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_in[0] && !$past(irq_in[0])) |=> mode[2]);
  p_fall_ch1_r5: assert property (@(posedge clk) disable iff (rst)
    (!irq_in[1] && $past(irq_in[1])) |=> !mode[3]);

  // R6: block write loads, otherwise block bits hold
  p_blk_load_r6: assert property (@(posedge clk) disable iff (rst)
    blk_we |=> (mode[5:4] == $past(blk_val)));
  p_blk_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !blk_we |=> $stable(mode[5:4]));

  // R7: output level agrees with the stored state
  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_out == ((mode[2] && !mode[4]) || (mode[3] && !mode[5])));

endmodule

bind irqm_top irqm_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_in  (irq_in),
  .wr_en   (wr_en),
  .wr_dw   (wr_dw),
  .wr_strb (wr_strb),
  .wr_data (wr_data),
  .blk_we  (blk_we),
  .blk_val (blk_val),
  .irq_out (irq_out),
  .leg0    (regs_q.leg0),
  .leg1    (regs_q.leg1),
  .mode    (regs_q.mode)
);

// File: tb/tb_irqm_top.sv
module tb_irqm_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  irq_in;
  logic        wr_en;
  logic [5:0]  wr_dw;
  logic [3:0]  wr_strb;
  logic [31:0] wr_data;
  logic        blk_we;
  logic [1:0]  blk_val;
  logic [5:0]  rd_dw;
  logic [31:0] rd_data;
  logic [31:0] rd_data_p;
  logic        irq_out;
  logic        irq_out_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqm_top #(.SECONDARY_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_dw(wr_dw),
    .wr_strb(wr_strb), .wr_data(wr_data), .blk_we(blk_we), .blk_val(blk_val),
    .rd_dw(rd_dw), .rd_data(rd_data), .irq_out(irq_out)
  );

  irqm_top #(.SECONDARY_EN(1'b0)) dut_p (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_dw(wr_dw),
    .wr_strb(wr_strb), .wr_data(wr_data), .blk_we(blk_we), .blk_val(blk_val),
    .rd_dw(rd_dw), .rd_data(rd_data_p), .irq_out(irq_out_p)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit armed  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m [0:255];
  logic [1:0] pv;
  logic       irq_e;
  int         ma;
  logic [7:0] md;

  function automatic void leg_from_mode();
    m[8'h50][2] = m[8'h71][2];
    m[8'h57][4] = m[8'h71][3];
  endfunction

  function automatic void mode_from_leg();
    m[8'h71][2] = m[8'h50][2];
    m[8'h71][3] = m[8'h57][4];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 256; a++) m[a] = 8'h00;
      m[8'h51] = 8'h0C;
      m[8'h09] = 8'h8F;
      m[8'h3D] = 8'h01;
      pv    = 2'b00;
      irq_e = 1'b0;
      armed = 1'b1;
    end else begin
      if (blk_we) begin
        m[8'h71][4] = blk_val[0];
        m[8'h71][5] = blk_val[1];
        leg_from_mode();
      end
      if (wr_en) begin
        for (int i = 0; i < 4; i++) begin
          if (wr_strb[i]) begin
            ma = int'(wr_dw) * 4 + i;
            md = wr_data[8*i +: 8];
            if (ma == 8'h50) begin
              m[ma] = m[ma] & ~(md & 8'h04);
              mode_from_leg();
            end else if (ma == 8'h57) begin
              m[ma] = m[ma] & ~(md & 8'h10);
              mode_from_leg();
            end else if (ma == 8'h71) begin
              m[ma] = m[ma] & ~(md & 8'h0C);
              leg_from_mode();
            end else if (ma == 8'h51) begin
              m[ma] = md;
            end
          end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (irq_in[c] && !pv[c])      m[8'h71][2+c] = 1'b1;
        else if (!irq_in[c] && pv[c]) m[8'h71][2+c] = 1'b0;
      end
      leg_from_mode();
      pv    = irq_in;
      irq_e = (m[8'h71][2] && !m[8'h71][4]) || (m[8'h71][3] && !m[8'h71][5]);
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] dw);
    int b;
    b = int'(dw) * 4;
    return {m[b+3], m[b+2], m[b+1], m[b]};
  endfunction

  function automatic string rd_tag(input logic [5:0] dw);
    if (dw == 6'h14 || dw == 6'h15) return "R1";
    if (dw == 6'h1C)                return "R2";
    return "R9";
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(rd_tag(rd_dw), rd_data, exp_rd(rd_dw));
      chk("R7", {31'd0, irq_out}, {31'd0, irq_e});
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en  = 1'b0;
    blk_we = 1'b0;
  endtask

  task automatic cfg_wr(input logic [5:0] dw, input logic [3:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_dw = dw; wr_strb = s; wr_data = d;
  endtask

  task automatic look(input string tag, input logic [5:0] dw, input logic [31:0] exp);
    rd_dw = dw;
    @(negedge clk);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  logic [5:0] dws [6] = '{6'h14, 6'h15, 6'h1C, 6'h0F, 6'h02, 6'h10};

  initial begin
    rst = 1'b1; irq_in = 2'b00; wr_en = 1'b0; wr_dw = '0; wr_strb = '0;
    wr_data = '0; blk_we = 1'b0; blk_val = 2'b00; rd_dw = 6'h1C;
    tick(); tick();
    rst = 1'b0;

    // R11: reset state
    look("R11", 6'h1C, 32'h0000_0000);
    chk("R11", {31'd0, irq_out}, 32'd0);
    // R8: control byte reset value for both parameter settings
    look("R8", 6'h14, 32'h0000_0C00);
    chk("R8", rd_data_p, 32'h0000_0400);
    // R9: constant bytes
    look("R9", 6'h02, 32'h0000_8F00);
    look("R9", 6'h0F, 32'h0000_0100);

    // R5 R2 R1 R7: channel 0 rises
    irq_in = 2'b01; tick();
    look("R2", 6'h1C, 32'h0000_0400);
    look("R1", 6'h14, 32'h0000_0C04);
    chk("R7", {31'd0, irq_out}, 32'd1);

    // R6: block channel 0 suppresses
    blk_we = 1'b1; blk_val = 2'b01; tick();
    look("R6", 6'h1C, 32'h0000_1400);
    chk("R7", {31'd0, irq_out}, 32'd0);
    blk_we = 1'b1; blk_val = 2'b00; tick();
    look("R6", 6'h1C, 32'h0000_0400);
    chk("R7", {31'd0, irq_out}, 32'd1);

    // R4: clear through legacy byte clears the mode copy
    cfg_wr(6'h14, 4'b0001, 32'h0000_0004); tick();
    look("R4", 6'h1C, 32'h0000_0000);
    chk("R4", {31'd0, irq_out}, 32'd0);

    // R3: zeros keep pending, ones elsewhere are ignored
    irq_in = 2'b00; tick();
    irq_in = 2'b01; tick();
    cfg_wr(6'h1C, 4'b1111, 32'hFFFF_F3FF); tick();
    look("R3", 6'h1C, 32'h0000_0400);
    look("R3", 6'h14, 32'h0000_0C04);

    // R10: rise on channel 1 beats a same-cycle clear of its flag
    irq_in = 2'b11; cfg_wr(6'h15, 4'b1000, 32'h1000_0000); tick();
    look("R10", 6'h15, 32'h1000_0000);
    look("R10", 6'h1C, 32'h0000_0C00);

    // R5: falling levels clear both copies
    irq_in = 2'b00; tick();
    look("R5", 6'h1C, 32'h0000_0000);
    look("R5", 6'h15, 32'h0000_0000);

    // R8: control byte is writable
    cfg_wr(6'h14, 4'b0010, 32'h0000_A500); tick();
    look("R8", 6'h14, 32'h0000_A500);

    // R9: writes to constant bytes have no effect
    cfg_wr(6'h0F, 4'b1111, 32'hFFFF_FFFF); tick();
    look("R9", 6'h0F, 32'h0000_0100);

    // R11: level held high through reset is a rise after reset
    irq_in = 2'b01; rst = 1'b1; tick(); tick();
    rst = 1'b0;
    look("R11", 6'h1C, 32'h0000_0000);
    tick();
    look("R11", 6'h1C, 32'h0000_0400);
    look("R8", 6'h14, 32'h0000_0C04);

    // random mix, compared every clock against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ 2'($urandom_range(1, 3));
      if ($urandom_range(0, 2) == 0)
        cfg_wr(dws[$urandom_range(0, 5)], 4'($urandom_range(0, 15)), $urandom);
      if ($urandom_range(0, 7) == 0) begin
        blk_we = 1'b1; blk_val = 2'($urandom_range(0, 3));
      end
      rd_dw = dws[$urandom_range(0, 5)];
      tick();
    end
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule